// File: doc/BRIEF.md
# Floating-Point Status and Trap Register

This block holds the 16-bit status and mode word of a floating-point unit. It sits beside the arithmetic datapath. Software writes the whole word through a load port and reads it back through a store port. Whenever the datapath finishes an instruction, it presents the completion: a strobe, the exception code it detected, a separate inexact indication, a qualifier saying whether the instruction was itself a status load or store, and the instruction word.

From these inputs the block works out which single exception code to record. It updates the sticky underflow and inexact flags and raises a one-cycle trap request when the recorded condition calls for one. Some conditions always trap. Underflow and inexact trap only when their enable bits are set, but they are recorded either way. The block also recognises two reserved instruction encodings and reports them as illegal instructions. The arithmetic itself lives elsewhere.

Top module: `fpu_status_reg`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears all 16 bits of rd_data and trap_req by the following edge.
- R2: A software write (wr_en) loads all 16 bits, which rd_data returns from the next cycle. The layout is: bits 2..0 trap code, bit 3 underflow trap enable, bit 4 underflow flag, bit 5 inexact trap enable, bit 6 inexact flag, bits 8..7 rounding mode, bits 15..9 software field. A write has priority over a completion in the same cycle; that completion is then dropped and raises no trap.
- R3: A completion that is not a status load/store, has exc_code 000 and no inexact, and is not illegal sets the trap code to 000 and raises no trap.
- R4: A completion with cmpl_is_status high that is not illegal leaves all 16 bits unchanged and raises no trap.
- R5: exc_code values 010 (overflow), 011 (divide by zero), 100 (illegal) and 101 (invalid operation) are recorded as the trap code. trap_req is high for exactly the cycle after that completion.
- R6: An instruction word whose bits 7..0 are 10111110 and whose bits 13..10 are 0011 or 1001 records code 100 and traps. This holds regardless of the exception inputs and the status qualifier. All other bits of the word are ignored.
- R7: exc_code 001 records underflow and sets the underflow flag. It traps only if the underflow enable (bit 3) is 1.
- R8: Inexact with exc_code 000 records 110 and sets the inexact flag. It traps only if the inexact enable (bit 5) is 1.
- R9: When inexact coincides with any other recorded exception, the other code is recorded and the inexact flag is left unchanged.
- R10: The underflow and inexact flags are sticky: once set, only reset or a software write of 0 clears them.
- R11: Completions never alter the rounding mode, the two trap enables or the software field.
- R12: exc_code values 110 and 111 are treated as no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software load of the status word |
| wr_data | input | 16 | Value to load |
| rd_data | output | 16 | Current status word (store port) |
| cmpl_valid | input | 1 | Instruction completion strobe |
| cmpl_is_status | input | 1 | Completing instruction is a status load or store |
| cmpl_exc_code | input | 3 | Exception detected by the datapath, trap-code encoding |
| cmpl_inexact | input | 1 | Result needed rounding |
| cmpl_opcode | input | 24 | Instruction word of the completing instruction |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Completions are driven with each exception code alone, and with inexact both alone and combined with underflow and overflow. Together these separate the code priority from the flag update. Underflow and inexact are each run with their enable on and off, which shows that recording is independent of trapping. Both illegal encodings are driven with status and exception inputs active, beside a near-miss word, to test the decode against the override. Clean and status-qualified completions after a nonzero code, same-cycle writes, and writes of zero to set flags cover clearing, retention and write priority.

// File: rtl/fsr_pkg.sv
// Shared types and constants for the floating-point status register.
// Assumes the 16-bit layout given in the brief; field order is fixed by software.
package fsr_pkg;
    typedef enum logic [2:0] {
        TT_NONE    = 3'd0,
        TT_UNDER   = 3'd1,
        TT_OVER    = 3'd2,
        TT_DIVZ    = 3'd3,
        TT_ILLEGAL = 3'd4,
        TT_INVALID = 3'd5,
        TT_INEXACT = 3'd6,
        TT_RSVD    = 3'd7
    } tt_e;

    localparam int SWF_W  = 7;
    localparam int RM_W   = 2;
    localparam int WORD_W = SWF_W + RM_W + 4 + 3;

    typedef struct packed {
        logic [SWF_W-1:0] swf;
        logic [RM_W-1:0]  rmode;
        logic             inx_flag;
        logic             inx_en;
        logic             unf_flag;
        logic             unf_en;
        tt_e              tcode;
    } fsr_t;

    localparam int          NUM_ILL  = 2;
    localparam logic [7:0]  OP_BYTE  = 8'b1011_1110;
    localparam logic [3:0]  ILL_SEL [NUM_ILL] = '{4'b0011, 4'b1001};
endpackage

// File: rtl/fsr_illegal_dec.sv
// Recognises the reserved floating-point instruction encodings.
// Assumes the opcode byte sits in bits 7..0 and the selector in bits 13..10.
module fsr_illegal_dec
    import fsr_pkg::*;
#(
    parameter int OPC_W = 24
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             illegal
);
    logic [NUM_ILL-1:0] hit;

    // One comparator per reserved selector value.
    for (genvar g = 0; g < NUM_ILL; g++) begin : g_pat
        assign hit[g] = (opcode[7:0] == OP_BYTE) && (opcode[13:10] == ILL_SEL[g]);
    end

    assign illegal = |hit;
endmodule

// File: rtl/fsr_exc_resolve.sv
// Chooses the single trap code for a completing instruction and the trap decision.
// Assumes exc_code uses the trap-code encoding; 110/111 there mean nothing.
module fsr_exc_resolve
    import fsr_pkg::*;
(
    input  logic       illegal,
    input  logic       is_status,
    input  logic [2:0] exc_code,
    input  logic       inexact,
    input  logic       unf_en,
    input  logic       inx_en,
    output logic       upd,
    output tt_e        code,
    output logic       set_unf,
    output logic       set_inx,
    output logic       trap
);
    // Priority: illegal decode, then status qualifier, then datapath code, then inexact.
    always_comb begin
        upd  = 1'b1;
        code = TT_NONE;
        if (illegal) begin
            code = TT_ILLEGAL;
        end else if (is_status) begin
            upd = 1'b0;
        end else begin
            unique case (exc_code)
                3'd1, 3'd2, 3'd3, 3'd4, 3'd5: code = tt_e'(exc_code);
                default:                      code = inexact ? TT_INEXACT : TT_NONE;
            endcase
        end
    end

    // Flag updates and trap request for the chosen code.
    always_comb begin
        set_unf = upd && (code == TT_UNDER);
        set_inx = upd && (code == TT_INEXACT);
        trap    = 1'b0;
        if (upd) begin
            unique case (code)
                TT_OVER, TT_DIVZ, TT_ILLEGAL, TT_INVALID: trap = 1'b1;
                TT_UNDER:   trap = unf_en;
                TT_INEXACT: trap = inx_en;
                default:    trap = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fsr_state.sv
// Holds the status word and the registered trap request.
// Assumes a software write wins over a completion in the same cycle.
module fsr_state
    import fsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  fsr_t   wr_word,
    input  logic   cmpl_valid,
    input  logic   upd,
    input  tt_e    code,
    input  logic   set_unf,
    input  logic   set_inx,
    input  logic   trap_in,
    output fsr_t   word_q,
    output logic   trap_q
);
    // Register update: reset, software load, or completion result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            trap_q <= 1'b0;
        end else begin
            trap_q <= 1'b0;
            if (wr_en) begin
                word_q <= wr_word;
            end else if (cmpl_valid && upd) begin
                word_q.tcode <= code;
                if (set_unf) word_q.unf_flag <= 1'b1;
                if (set_inx) word_q.inx_flag <= 1'b1;
                trap_q <= trap_in;
            end
        end
    end
endmodule

// File: rtl/fpu_status_reg.sv
// Floating-point status/mode register with exception priority and trap request.
// Assumes one completion per cycle at most; trap_req follows a completion by one cycle.
module fpu_status_reg
    import fsr_pkg::*;
#(
    parameter int OPC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cmpl_valid,
    input  logic              cmpl_is_status,
    input  logic [2:0]        cmpl_exc_code,
    input  logic              cmpl_inexact,
    input  logic [OPC_W-1:0]  cmpl_opcode,
    output logic              trap_req
);
    fsr_t word_q;
    logic illegal, upd, set_unf, set_inx, trap_c;
    tt_e  code;

    fsr_illegal_dec #(.OPC_W(OPC_W)) u_dec (
        .opcode  (cmpl_opcode),
        .illegal (illegal)
    );

    fsr_exc_resolve u_res (
        .illegal   (illegal),
        .is_status (cmpl_is_status),
        .exc_code  (cmpl_exc_code),
        .inexact   (cmpl_inexact),
        .unf_en    (word_q.unf_en),
        .inx_en    (word_q.inx_en),
        .upd       (upd),
        .code      (code),
        .set_unf   (set_unf),
        .set_inx   (set_inx),
        .trap      (trap_c)
    );

    fsr_state u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (fsr_t'(wr_data)),
        .cmpl_valid (cmpl_valid),
        .upd        (upd),
        .code       (code),
        .set_unf    (set_unf),
        .set_inx    (set_inx),
        .trap_in    (trap_c),
        .word_q     (word_q),
        .trap_q     (trap_req)
    );

    assign rd_data = word_q;
endmodule

// File: rtl/fsr_status_chk.sv
// Temporal checks on the status register's ports, bound to every instance.
module fsr_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        cmpl_valid,
    input logic        cmpl_is_status,
    input logic [2:0]  cmpl_exc_code,
    input logic        cmpl_inexact,
    input logic [23:0] cmpl_opcode,
    input logic        trap_req
);
    logic ill_word;
    assign ill_word = (cmpl_opcode[7:0] == 8'hBE) &&
                      (cmpl_opcode[13:10] == 4'b0011 || cmpl_opcode[13:10] == 4'b1001);

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (rd_data == '0 && !trap_req));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data) && !trap_req));

    a_r3_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && !wr_en && !cmpl_is_status && !ill_word && cmpl_exc_code == 3'd0 && !cmpl_inexact)
        |=> (rd_data[2:0] == 3'd0 && !trap_req));

    a_r4_status_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && !wr_en && cmpl_is_status && !ill_word) |=> ($stable(rd_data) && !trap_req));

    a_r5_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(cmpl_valid && !wr_en));

    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !wr_en) |=> rd_data[4]);

    a_r10_inx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[6] && !wr_en) |=> rd_data[6]);

    a_r11_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({rd_data[15:7], rd_data[5], rd_data[3]}));
endmodule

bind fpu_status_reg fsr_status_chk u_chk (.*);

// File: tb/tb_fpu_status_reg.sv
`timescale 1ns/1ps
module tb_fpu_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cmpl_valid = 1'b0;
    logic        cmpl_is_status = 1'b0;
    logic [2:0]  cmpl_exc_code = '0;
    logic        cmpl_inexact = 1'b0;
    logic [23:0] cmpl_opcode = '0;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] m_word = '0;
    logic        m_trap = 1'b0;

    always #2.5 clk = ~clk;

    fpu_status_reg dut (.*);

    // Reference model: one clock edge of expected behaviour.
    task automatic model_edge();
        int code;
        bit ill;
        m_trap = 1'b0;
        if (!rst_n) begin
            m_word = '0;
        end else if (wr_en) begin
            m_word = wr_data;
        end else if (cmpl_valid) begin
            ill = (cmpl_opcode[7:0] == 8'hBE) &&
                  (cmpl_opcode[13:10] == 4'h3 || cmpl_opcode[13:10] == 4'h9);
            if (ill) code = 4;
            else if (cmpl_is_status) code = -1;
            else if (cmpl_exc_code >= 1 && cmpl_exc_code <= 5) code = int'(cmpl_exc_code);
            else if (cmpl_inexact) code = 6;
            else code = 0;
            if (code >= 0) begin
                m_word[2:0] = 3'(code);
                if (code == 1) m_word[4] = 1'b1;
                if (code == 6) m_word[6] = 1'b1;
                m_trap = (code >= 2 && code <= 5) || (code == 1 && m_word[3]) || (code == 6 && m_word[5]);
            end
        end
    endtask

    // Drive one cycle of inputs, advance, then compare both outputs.
    task automatic step(input bit wr, input logic [15:0] wd, input bit cv, input bit st,
                        input logic [2:0] exc, input bit inx, input logic [23:0] op, input string tag);
        wr_en = wr; wr_data = wd; cmpl_valid = cv; cmpl_is_status = st;
        cmpl_exc_code = exc; cmpl_inexact = inx; cmpl_opcode = op;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (rd_data !== m_word || trap_req !== m_trap) begin
            errors++;
            $display("FAIL %s: rd_data=%h trap_req=%b expected rd_data=%h trap_req=%b",
                     tag, rd_data, trap_req, m_word, m_trap);
        end
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, 0, 3'd0, 0, '0, tag);
    endtask

    task automatic done_op(input logic [2:0] exc, input bit inx, input string tag);
        step(0, '0, 1, 0, exc, inx, 24'h000000, tag);
    endtask

    task automatic load(input logic [15:0] wd, input string tag);
        step(1, wd, 0, 0, 3'd0, 0, '0, tag);
    endtask

    initial begin
        @(negedge clk);
        idle("R1"); idle("R1");
        rst_n = 1'b1;
        load(16'hAB28, "R2");
        idle("R2");
        done_op(3'd2, 0, "R5");
        done_op(3'd3, 0, "R5");
        done_op(3'd5, 0, "R5");
        done_op(3'd4, 0, "R5");
        idle("R5");
        done_op(3'd0, 0, "R3");
        done_op(3'd2, 0, "R5");
        step(0, '0, 1, 1, 3'd3, 1, '0, "R4");
        idle("R4");
        done_op(3'd1, 0, "R7");
        load(16'hAB20, "R2");
        done_op(3'd1, 0, "R7");
        done_op(3'd0, 0, "R10");
        done_op(3'd0, 1, "R8");
        load(16'hAB08, "R2");
        done_op(3'd0, 1, "R8");
        done_op(3'd0, 0, "R10");
        load(16'hAB28, "R2");
        done_op(3'd2, 1, "R9");
        done_op(3'd1, 1, "R9");
        done_op(3'd0, 1, "R8");
        done_op(3'd3, 1, "R9");
        done_op(3'd0, 0, "R11");
        load(16'hAB28 & ~16'h0050, "R10");
        step(0, '0, 1, 1, 3'd2, 1, {10'h2AB, 4'b0011, 2'b10, 8'hBE}, "R6");
        step(0, '0, 1, 0, 3'd5, 0, {10'h155, 4'b1001, 2'b01, 8'hBE}, "R6");
        step(0, '0, 1, 0, 3'd0, 0, {10'h3FF, 4'b0011, 2'b11, 8'hBF}, "R6");
        step(0, '0, 1, 0, 3'd0, 0, {10'h000, 4'b0111, 2'b00, 8'hBE}, "R6");
        done_op(3'd2, 0, "R5");
        done_op(3'd6, 0, "R12");
        done_op(3'd2, 0, "R5");
        done_op(3'd7, 0, "R12");
        step(1, 16'h1234, 1, 0, 3'd2, 0, '0, "R2");
        idle("R2");
        load(16'hFFFF, "R2");
        rst_n = 1'b0;
        idle("R1");
        rst_n = 1'b1;
        idle("R1");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is one more failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule